// File: doc/BRIEF.md
# Configurable Three-Input Logic Tile

The tile is one cell of a programmable fabric. A configuration word, loaded before operation and then held steady, turns it into one of four things: a lookup table that realises any Boolean function of three inputs, a level-sensitive latch, a rising-edge D flip-flop, or a D flip-flop with a clock enable. Every one of its four data pins passes through its own configurable inverter before any other use. In the three storage modes, the last pin is a dedicated asynchronous control. It forces the stored value to 1 or to 0, and the configuration selects which.

The single result is driven onto two output ports, one meant for short local routing and one for long-line routing. The clock is a plain global input. The active-low reset clears both storage elements. There is no data stream at the edge of the block, so every pin is a plain level signal without a handshake.

Top module: `cell_tile`

## Requirements
- R1: While `rst_n` is low, the latch and the flip-flop both hold 0, so in every storage mode both outputs read 0.
- R2: Configuration word layout: bits [7:0] are the truth table, bits [9:8] the mode (0 = logic, 1 = latch, 2 = flip-flop, 3 = enabled flip-flop), bit 10 selects set (1) or clear (0), and bits [14:11] are the inversion mask. In logic mode the output is truth-table bit {p2,p1,p0}, with p2 as the most significant index bit, where pk is pin k after inversion.
- R3: Inversion-mask bit k inverts pin k before the pin is used in any mode, including its use as the asynchronous control.
- R4: In latch mode, while p2 (the gate) is high, the output follows p0.
- R5: In latch mode, while the gate is low, the output keeps its value whatever p0 does.
- R6: In flip-flop mode, the output takes the value of p0 at every rising edge of `clk`.
- R7: In enabled flip-flop mode, p0 is captured at a rising edge only when p1 (the enable) is high. Otherwise the value is held across clock edges.
- R8: In every storage mode, a high p3 forces the stored value to the set/clear choice at once, without waiting for a clock. It overrides the clock, the enable and the gate. In logic mode p3 has no effect.
- R9: Both output ports always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flip-flop modes |
| rst_n | input | 1 | Asynchronous active-low reset of the storage |
| cfg_i | input | 15 | Configuration word (layout in R2) |
| pin_i | input | 4 | Data pins p0..p3 before inversion |
| y_local_o | output | 1 | Result for local routing |
| y_long_o | output | 1 | Result for long-line routing |

## Verification
The bench builds the tile with the default of three lookup inputs. This gives an eight-entry table and a four-pin cell, so random truth tables and inversion masks reach every table index, and every pin is exercised in both polarities. Directed sequences cover the following:
- set against clear;
- the asynchronous control overriding an active enable and an open gate;
- hold with the enable or the gate low;
- the control pin being ignored in logic mode.

In latch mode, the random stimulus toggles one pin per step, so the gate never closes in the same step that the data changes.

// File: rtl/cell_tile_pkg.sv
package cell_tile_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_LOGIC   = 2'd0,
    MODE_LATCH   = 2'd1,
    MODE_FLOP    = 2'd2,
    MODE_FLOP_EN = 2'd3
  } cell_mode_e;
endpackage

// File: rtl/cell_pin_polarity.sv
module cell_pin_polarity #(
  parameter int NPINS = 4
) (
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] inv_i,
  output logic [NPINS-1:0] eff_o
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign eff_o[g] = pin_i[g] ^ inv_i[g];
  end
endmodule

// File: rtl/cell_lut.sv
module cell_lut #(
  parameter int LUT_INPUTS = 3,
  localparam int TBL = 1 << LUT_INPUTS
) (
  input  logic [TBL-1:0]        table_i,
  input  logic [LUT_INPUTS-1:0] sel_i,
  output logic                  out_o
);
  // binary mux tree, one level per select bit
  logic [TBL-1:0] lvl [LUT_INPUTS+1];
  assign lvl[0] = table_i;
  for (genvar l = 0; l < LUT_INPUTS; l++) begin : g_lvl
    localparam int W = TBL >> (l + 1);
    for (genvar k = 0; k < W; k++) begin : g_node
      assign lvl[l+1][k] = sel_i[l] ? lvl[l][2*k+1] : lvl[l][2*k];
    end
    if (W < TBL) begin : g_pad
      assign lvl[l+1][TBL-1:W] = '0;
    end
  end
  assign out_o = lvl[LUT_INPUTS][0];
endmodule

// File: rtl/cell_latch.sv
module cell_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  input  logic gate_i,
  input  logic sc_i,
  input  logic sc_val_i,
  output logic q_o
);
  always_latch begin
    if (!rst_n)      q_o <= 1'b0;
    else if (sc_i)   q_o <= sc_val_i;
    else if (gate_i) q_o <= d_i;
  end

  // open gate passes data (R4)
  p_latch_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_i && !sc_i) |-> (q_o == d_i));
  // async control forces value (R8)
  p_latch_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sc_i |-> (q_o == sc_val_i));
endmodule

// File: rtl/cell_flop.sv
module cell_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  input  logic load_i,
  input  logic sc_i,
  input  logic sc_val_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n or posedge sc_i) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (sc_i)   q_o <= sc_val_i;
    else if (load_i) q_o <= d_i;
  end

  // capture on an enabled edge (R6)
  p_flop_load_r6: assert property (@(posedge clk) disable iff (!rst_n || sc_i)
    load_i |=> (q_o == $past(d_i)));
  // no load, no change (R7)
  p_flop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n || sc_i)
    !load_i |=> $stable(q_o));
  // async control wins (R8)
  p_flop_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sc_i |-> (q_o == sc_val_i));
endmodule

// File: rtl/cell_tile.sv
module cell_tile
  import cell_tile_pkg::*;
#(
  parameter int LUT_INPUTS = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [(1<<LUT_INPUTS)+LUT_INPUTS+3:0] cfg_i,
  input  logic [LUT_INPUTS:0]                   pin_i,
  output logic                                  y_local_o,
  output logic                                  y_long_o
);
  localparam int TBL      = 1 << LUT_INPUTS;
  localparam int NPINS    = LUT_INPUTS + 1;
  localparam int MODE_LSB = TBL;
  localparam int SCV_BIT  = TBL + MODE_W;
  localparam int INV_LSB  = SCV_BIT + 1;
  localparam int PIN_D    = 0;
  localparam int PIN_EN   = 1;
  localparam int PIN_GATE = 2;
  localparam int PIN_SC   = LUT_INPUTS;

  logic [TBL-1:0]   tbl;
  cell_mode_e       mode;
  logic             sc_val;
  logic [NPINS-1:0] inv, eff;
  logic             lut_y, latch_q, flop_q, y;
  logic             is_seq, sc_act, gate, load;

  assign tbl    = cfg_i[TBL-1:0];
  assign mode   = cell_mode_e'(cfg_i[MODE_LSB +: MODE_W]);
  assign sc_val = cfg_i[SCV_BIT];
  assign inv    = cfg_i[INV_LSB +: NPINS];

  cell_pin_polarity #(.NPINS(NPINS)) u_pol (
    .pin_i(pin_i), .inv_i(inv), .eff_o(eff)
  );

  cell_lut #(.LUT_INPUTS(LUT_INPUTS)) u_lut (
    .table_i(tbl), .sel_i(eff[LUT_INPUTS-1:0]), .out_o(lut_y)
  );

  assign is_seq = (mode != MODE_LOGIC);
  assign sc_act = is_seq && eff[PIN_SC];
  assign gate   = (mode == MODE_LATCH) && eff[PIN_GATE];
  assign load   = (mode == MODE_FLOP) || ((mode == MODE_FLOP_EN) && eff[PIN_EN]);

  cell_latch u_latch (
    .clk(clk), .rst_n(rst_n), .d_i(eff[PIN_D]), .gate_i(gate),
    .sc_i(sc_act), .sc_val_i(sc_val), .q_o(latch_q)
  );

  cell_flop u_flop (
    .clk(clk), .rst_n(rst_n), .d_i(eff[PIN_D]), .load_i(load),
    .sc_i(sc_act), .sc_val_i(sc_val), .q_o(flop_q)
  );

  always_comb begin
    case (mode)
      MODE_LOGIC: y = lut_y;
      MODE_LATCH: y = latch_q;
      default:    y = flop_q;
    endcase
  end

  assign y_local_o = y;
  assign y_long_o  = y;

  // storage is clear while reset is held (R1)
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (!latch_q && !flop_q));
endmodule

// File: tb/test_cell_tile.sv
module test_cell_tile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] cfg_i = '0;
  logic [3:0]  pin_i = '0;
  logic        y_local_o, y_long_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic m_ff  = 1'b0;
  logic m_lat = 1'b0;

  always #5 clk = ~clk;

  cell_tile i_cell_tile (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .pin_i(pin_i),
    .y_local_o(y_local_o), .y_long_o(y_long_o)
  );

  function automatic logic [14:0] mk(input logic [7:0] t, input logic [1:0] m,
                                     input logic sv, input logic [3:0] iv);
    return {iv, sv, m, t};
  endfunction

  function automatic logic [3:0] eff_now();
    return pin_i ^ cfg_i[14:11];
  endfunction

  function automatic logic exp_out();
    logic [3:0] e;
    e = eff_now();
    case (cfg_i[9:8])
      2'd0:    return cfg_i[e[2:0]];
      2'd1:    return m_lat;
      default: return m_ff;
    endcase
  endfunction

  task automatic m_async();
    logic [3:0] e;
    e = eff_now();
    if (cfg_i[9:8] != 2'd0 && e[3]) begin
      m_lat = cfg_i[10];
      m_ff  = cfg_i[10];
    end else if (cfg_i[9:8] == 2'd1 && e[2]) begin
      m_lat = e[0];
    end
  endtask

  task automatic m_clock();
    logic [3:0] e;
    e = eff_now();
    if (!(cfg_i[9:8] != 2'd0 && e[3])) begin
      if (cfg_i[9:8] == 2'd2 || (cfg_i[9:8] == 2'd3 && e[1])) m_ff = e[0];
    end
  endtask

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (y_local_o !== exp) begin
      fails++;
      $display("FAIL %s: y_local=%b expected %b", tag, y_local_o, exp);
    end
    checks++;
    if (y_long_o !== exp) begin
      fails++;
      $display("FAIL R9 (%s): y_long=%b expected %b", tag, y_long_o, exp);
    end
  endtask

  task automatic step(input logic [14:0] c, input logic [3:0] p, input string tag);
    @(negedge clk);
    cfg_i = c;
    pin_i = p;
    #1;
    m_async();
    chk(exp_out(), tag);
    @(posedge clk);
    #1;
    m_clock();
    m_async();
    chk(exp_out(), tag);
  endtask

  initial begin
    logic [3:0] p;
    logic [14:0] c;
    void'($urandom(32'd20250117));

    // R1: reset clears storage
    cfg_i = mk(8'h00, 2'd2, 1'b1, 4'b0000);
    pin_i = 4'b0001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(1'b0, "R1 flop mode under reset");
    cfg_i = mk(8'h00, 2'd1, 1'b1, 4'b0000);
    pin_i = 4'b0101;
    #1;
    chk(1'b0, "R1 latch mode under reset");
    pin_i = 4'b0000;
    cfg_i = mk(8'h00, 2'd0, 1'b0, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: table index order
    step(mk(8'h10, 2'd0, 1'b0, 4'b0000), 4'b0100, "R2 index 4 from p2");
    step(mk(8'h10, 2'd0, 1'b0, 4'b0000), 4'b0001, "R2 index 1 is zero");
    step(mk(8'h10, 2'd0, 1'b0, 4'b0000), 4'b1100, "R8 p3 ignored in logic mode");
    // R3: inversion
    step(mk(8'h10, 2'd0, 1'b0, 4'b0100), 4'b0000, "R3 inverted p2");
    step(mk(8'h96, 2'd0, 1'b0, 4'b1111), 4'b1111, "R3 all inverted parity");
    // latch: R4, R5, R8
    step(mk(8'h00, 2'd1, 1'b0, 4'b0000), 4'b0101, "R4 open gate passes 1");
    step(mk(8'h00, 2'd1, 1'b0, 4'b0000), 4'b0001, "R5 gate closed holds");
    step(mk(8'h00, 2'd1, 1'b0, 4'b0000), 4'b0000, "R5 data change ignored");
    step(mk(8'h00, 2'd1, 1'b0, 4'b0000), 4'b1000, "R8 latch clear");
    step(mk(8'h00, 2'd1, 1'b0, 4'b0000), 4'b1100, "R8 clear beats open gate");
    step(mk(8'h00, 2'd1, 1'b0, 4'b0000), 4'b1101, "R8 clear beats data");
    step(mk(8'h00, 2'd1, 1'b0, 4'b0000), 4'b0101, "R4 release follows data");
    step(mk(8'h00, 2'd1, 1'b0, 4'b0000), 4'b0001, "R5 hold after release");
    // flop: R6
    step(mk(8'h00, 2'd2, 1'b1, 4'b0000), 4'b0001, "R6 capture 1");
    step(mk(8'h00, 2'd2, 1'b1, 4'b0000), 4'b0000, "R6 capture 0");
    // enabled flop: R7, R8
    step(mk(8'h00, 2'd3, 1'b1, 4'b0000), 4'b0011, "R7 enabled capture 1");
    step(mk(8'h00, 2'd3, 1'b1, 4'b0000), 4'b0010, "R7 enabled capture 0");
    step(mk(8'h00, 2'd3, 1'b1, 4'b0000), 4'b0001, "R7 enable low holds");
    step(mk(8'h00, 2'd3, 1'b1, 4'b0000), 4'b1000, "R8 async set");
    step(mk(8'h00, 2'd3, 1'b1, 4'b0000), 4'b1010, "R8 set beats enable");
    step(mk(8'h00, 2'd3, 1'b1, 4'b0000), 4'b0010, "R7 capture after release");
    step(mk(8'h00, 2'd3, 1'b1, 4'b1000), 4'b0000, "R3 inverted control sets");
    step(mk(8'h00, 2'd3, 1'b1, 4'b1000), 4'b1000, "R7 hold after inverted set");

    // random phases
    p = pin_i;
    for (int ph = 0; ph < 40; ph++) begin
      c = mk(8'($urandom), 2'($urandom), 1'($urandom), 4'($urandom));
      p = c[14:11];
      step(c, p, "R2 phase entry");
      for (int s = 0; s < 10; s++) begin
        if (c[9:8] == 2'd1) p = p ^ (4'b0001 << ($urandom % 4));
        else                p = 4'($urandom);
        case (c[9:8])
          2'd0:    step(c, p, "R2 random logic");
          2'd1:    step(c, p, "R4 random latch");
          2'd2:    step(c, p, "R6 random flop");
          default: step(c, p, "R7 random enabled flop");
        endcase
      end
      if (c[9:8] == 2'd1 && (p[2] ^ c[13])) begin
        p[2] = ~p[2];
        step(c, p, "R5 gate close before exit");
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule